// File: doc/BRIEF.md
# Ternary Frame Header Classifier

This block sorts ingress frames into forwarding decisions by matching each frame's leading header bytes against a small ternary rule table. An upstream parser hands over one header snapshot per beat on a valid/ready handshake. Each snapshot carries the first header bytes, a one-hot code for the port the frame arrived on, and the default destination port vector chosen by ordinary forwarding. Every table entry compares its data bytes to the header under a per-bit mask. It also applies a masked comparison against the source port, and only entries whose two frame-type gate bits are set may take part. When several entries hit, the entry at the lowest index wins. Its action then edits the default vector: it leaves it unchanged, ANDs it or ORs it with the entry vector, or replaces it with the entry vector.

The table storage and the engine that writes it sit outside this block. The block sees all entries at once through a flat, combinational read bus driven by that storage. The datapath has two register stages: an input capture stage and a result stage. Back-pressure from the consumer stalls both stages without losing a frame.

Top module: `hdr_ternary_classifier`

## Requirements
- R1: Header byte i occupies bits [8i+7:8i] of `in_hdr`. An entry's header test passes when ((header XOR entry data) AND entry mask) is all zero, so a zero mask byte makes that byte position a don't-care. In entry k, which is slice `tbl_flat[k*EW +: EW]` with EW = 16*HDR_BYTES + 3*N_PORTS + 4, the data bytes sit at bits [8*HDR_BYTES-1:0] and the mask bytes at the next 8*HDR_BYTES bits, with byte i at the same relative position as in `in_hdr`.
- R2: The source port test applies the same ternary rule between `in_src_port` and the entry's port key, under the entry's port mask. Within the entry, the port key follows the mask bytes and the port mask follows the port key, each N_PORTS bits wide.
- R3: An entry can hit only when both of its frame-type gate bits are 1. These two bits follow the port mask. An all-zero (flushed) entry never hits.
- R4: The action mode is the 2-bit field after the gate bits. The entry vector is the final N_PORTS bits of the entry. Mode 0 leaves the default vector unchanged, although `out_hit` is still 1.
- R5: Mode 1 outputs default AND entry vector, mode 2 outputs default OR entry vector, and mode 3 outputs the entry vector alone.
- R6: When several entries hit, the lowest-indexed one sets `out_idx` and supplies the action.
- R7: On a miss, `out_hit` is 0, `out_idx` is 0 and `out_vec` equals the default vector.
- R8: While `out_valid` is 1 and `out_ready` is 0, all result outputs hold steady.
- R9: A frame accepted on clock edge n is presented on `out_valid` after edge n+1. `in_ready` drops only when both stages are full and the result is stalled. One frame can be accepted per cycle when the output is not stalled.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Header snapshot offered |
| in_ready | output | 1 | Snapshot accepted this cycle when high with in_valid |
| in_hdr | input | 8*HDR_BYTES | Leading header bytes, byte 0 in the low bits |
| in_src_port | input | N_PORTS | One-hot ingress port |
| in_dflt_vec | input | N_PORTS | Default destination port vector |
| tbl_flat | input | N_ENT*EW | All table entries, entry k at slice k*EW |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | Some entry matched |
| out_idx | output | IDX_W | Index of the winning entry |
| out_vec | output | N_PORTS | Final destination port vector |

## Verification
The bench builds the block with four entries, the full 48-byte header and eleven ports. With four entries it can load a flushed slot, a gated-off slot and two overlapping matches together, which is enough to separate priority from gating. The full header width lets the rules key on the EtherType, IP protocol and IPv4 address positions that real rules use, including a prefix-style partial address mask. Eleven ports let the source-port key pick out one port among several.

// File: rtl/hdr_ternary_classifier.sv
module hdr_ternary_classifier #(
  parameter int N_ENT     = 4,
  parameter int HDR_BYTES = 48,
  parameter int N_PORTS   = 11,
  localparam int HW    = 8 * HDR_BYTES,
  localparam int EW    = 2 * HW + 3 * N_PORTS + 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [HW-1:0]          in_hdr,
  input  logic [N_PORTS-1:0]     in_src_port,
  input  logic [N_PORTS-1:0]     in_dflt_vec,
  input  logic [N_ENT*EW-1:0]    tbl_flat,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_hit,
  output logic [IDX_W-1:0]       out_idx,
  output logic [N_PORTS-1:0]     out_vec
);

  localparam int O_MASK = HW;
  localparam int O_SKEY = 2 * HW;
  localparam int O_SMSK = O_SKEY + N_PORTS;
  localparam int O_GATE = O_SMSK + N_PORTS;
  localparam int O_MODE = O_GATE + 2;
  localparam int O_DVEC = O_MODE + 2;

  logic               a_vld;
  logic [HW-1:0]      a_hdr;
  logic [N_PORTS-1:0] a_src;
  logic [N_PORTS-1:0] a_dflt;

  logic b_adv, a_adv;
  assign b_adv    = !out_valid || out_ready;
  assign a_adv    = !a_vld || b_adv;
  assign in_ready = a_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_hdr  <= '0;
      a_src  <= '0;
      a_dflt <= '0;
    end else if (a_adv) begin
      a_vld <= in_valid;
      if (in_valid) begin
        a_hdr  <= in_hdr;
        a_src  <= in_src_port;
        a_dflt <= in_dflt_vec;
      end
    end
  end

  logic [N_ENT-1:0] hv;

  for (genvar k = 0; k < N_ENT; k++) begin : g_ent
    logic [EW-1:0] ent;
    logic hdr_ok, src_ok, gate_ok;
    assign ent     = tbl_flat[k*EW +: EW];
    assign hdr_ok  = ((a_hdr ^ ent[0 +: HW]) & ent[O_MASK +: HW]) == '0;
    assign src_ok  = ((a_src ^ ent[O_SKEY +: N_PORTS]) & ent[O_SMSK +: N_PORTS]) == '0;
    assign gate_ok = &ent[O_GATE +: 2];
    assign hv[k]   = hdr_ok && src_ok && gate_ok;
  end

  logic [IDX_W-1:0]   win;
  logic [1:0]         win_mode;
  logic [N_PORTS-1:0] win_vec;
  logic [N_PORTS-1:0] nxt_vec;

  always_comb begin
    win      = '0;
    win_mode = 2'd0;
    win_vec  = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      if (hv[k]) begin
        win      = IDX_W'(k);
        win_mode = tbl_flat[k*EW + O_MODE +: 2];
        win_vec  = tbl_flat[k*EW + O_DVEC +: N_PORTS];
      end
    end
  end

  always_comb begin
    unique case (win_mode)
      2'd1:    nxt_vec = a_dflt & win_vec;
      2'd2:    nxt_vec = a_dflt | win_vec;
      2'd3:    nxt_vec = win_vec;
      default: nxt_vec = a_dflt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
      out_vec   <= '0;
    end else if (b_adv) begin
      out_valid <= a_vld;
      if (a_vld) begin
        out_hit <= |hv;
        out_idx <= win;
        out_vec <= nxt_vec;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_idx) && $stable(out_vec));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> int'(out_idx) < N_ENT);

  p_miss_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> out_idx == '0);

  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> a_vld);

  p_stall_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld && out_valid && !out_ready |=> a_vld && $stable(a_hdr) && $stable(a_dflt));

  p_promote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld && out_ready |=> out_valid);

endmodule

// File: tb/hdr_ternary_classifier_test.sv
module hdr_ternary_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int HB = 48;
  localparam int NP = 11;
  localparam int HW = 8 * HB;
  localparam int EW = 2 * HW + 3 * NP + 4;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [HW-1:0] in_hdr = '0;
  logic [NP-1:0] in_src_port = '0;
  logic [NP-1:0] in_dflt_vec = '0;
  logic [NE*EW-1:0] tbl_flat = '0;
  logic out_valid;
  logic out_ready = 1;
  logic out_hit;
  logic [1:0] out_idx;
  logic [NP-1:0] out_vec;

  int checks = 0;
  int fails = 0;

  logic [7:0]    e_data [NE][HB];
  logic [7:0]    e_mask [NE][HB];
  logic [NP-1:0] e_skey [NE];
  logic [NP-1:0] e_smsk [NE];
  logic [1:0]    e_gate [NE];
  logic [1:0]    e_mode [NE];
  logic [NP-1:0] e_dvec [NE];

  hdr_ternary_classifier #(.N_ENT(NE), .HDR_BYTES(HB), .N_PORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_src_port(in_src_port), .in_dflt_vec(in_dflt_vec),
    .tbl_flat(tbl_flat), .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_idx(out_idx), .out_vec(out_vec));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_tbl();
    for (int k = 0; k < NE; k++) begin
      for (int b = 0; b < HB; b++) begin e_data[k][b] = 0; e_mask[k][b] = 0; end
      e_skey[k] = 0; e_smsk[k] = 0; e_gate[k] = 0; e_mode[k] = 0; e_dvec[k] = 0;
    end
  endtask

  task automatic commit();
    for (int k = 0; k < NE; k++) begin
      for (int b = 0; b < HB; b++) begin
        tbl_flat[k*EW + b*8 +: 8]      = e_data[k][b];
        tbl_flat[k*EW + HW + b*8 +: 8] = e_mask[k][b];
      end
      tbl_flat[k*EW + 2*HW +: NP]          = e_skey[k];
      tbl_flat[k*EW + 2*HW + NP +: NP]     = e_smsk[k];
      tbl_flat[k*EW + 2*HW + 2*NP +: 2]    = e_gate[k];
      tbl_flat[k*EW + 2*HW + 2*NP + 2 +: 2] = e_mode[k];
      tbl_flat[k*EW + 2*HW + 2*NP + 4 +: NP] = e_dvec[k];
    end
  endtask

  task automatic set_rule(int k, int pos, logic [7:0] d, logic [7:0] m);
    e_data[k][pos] = d;
    e_mask[k][pos] = m;
  endtask

  // IPv4/TCP rule: EtherType 0x0800 at 16..17, protocol 6 at 27
  task automatic tcp_rule(int k, logic [1:0] mode, logic [NP-1:0] dv);
    set_rule(k, 16, 8'h08, 8'hff);
    set_rule(k, 17, 8'h00, 8'hff);
    set_rule(k, 27, 8'h06, 8'hff);
    e_gate[k] = 2'b11;
    e_mode[k] = mode;
    e_dvec[k] = dv;
  endtask

  function automatic logic [HW-1:0] base_frame();
    logic [HW-1:0] f;
    for (int i = 0; i < HB; i++) f[i*8 +: 8] = 8'(i + 8'h40);
    f[16*8 +: 8] = 8'h08; f[17*8 +: 8] = 8'h00; f[27*8 +: 8] = 8'h06;
    f[30*8 +: 8] = 8'd10; f[31*8 +: 8] = 8'd1; f[32*8 +: 8] = 8'd2; f[33*8 +: 8] = 8'd3;
    f[34*8 +: 8] = 8'd10; f[35*8 +: 8] = 8'd9; f[36*8 +: 8] = 8'd9; f[37*8 +: 8] = 8'd9;
    return f;
  endfunction

  function automatic logic [HW-1:0] with_byte(logic [HW-1:0] f, int pos, logic [7:0] v);
    f[pos*8 +: 8] = v;
    return f;
  endfunction

  task automatic classify(string tag, logic [HW-1:0] hdr, logic [NP-1:0] src,
                          logic [NP-1:0] dflt, logic ehit, logic [1:0] eidx,
                          logic [NP-1:0] evec);
    @(negedge clk);
    chk({tag, " R9 ready idle"}, in_ready, 1);
    in_valid = 1; in_hdr = hdr; in_src_port = src; in_dflt_vec = dflt;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R9 not early"}, out_valid, 0);
    @(negedge clk);
    chk({tag, " R9 valid"}, out_valid, 1);
    chk({tag, " hit"}, out_hit, ehit);
    chk({tag, " idx"}, out_idx, eidx);
    chk({tag, " vec"}, out_vec, evec);
  endtask

  task automatic t_reset();
    chk("R10 out_valid", out_valid, 0);
    chk("R10 in_ready", in_ready, 1);
  endtask

  task automatic t_flushed_miss();
    clear_tbl(); commit();
    classify("R3/R7 flushed", base_frame(), 11'h001, 11'h155, 0, 0, 11'h155);
  endtask

  task automatic t_bytes();
    clear_tbl(); tcp_rule(0, 2'd3, 11'h400); commit();
    classify("R1 exact", base_frame(), 11'h004, 11'h00f, 1, 0, 11'h400);
    classify("R1 proto mismatch", with_byte(base_frame(), 27, 8'h11), 11'h004, 11'h00f, 0, 0, 11'h00f);
    classify("R1 dont-care byte", with_byte(base_frame(), 5, 8'hee), 11'h004, 11'h00f, 1, 0, 11'h400);
    // /24 source prefix 10.1.2.x
    set_rule(0, 30, 8'd10, 8'hff); set_rule(0, 31, 8'd1, 8'hff); set_rule(0, 32, 8'd2, 8'hff);
    commit();
    classify("R1 prefix host", with_byte(base_frame(), 33, 8'd200), 11'h004, 11'h00f, 1, 0, 11'h400);
    classify("R1 prefix out", with_byte(base_frame(), 32, 8'd3), 11'h004, 11'h00f, 0, 0, 11'h00f);
    // partial mask bits: only high nibble of byte 36 compared
    set_rule(0, 36, 8'h00, 8'hf0); commit();
    classify("R1 nibble mask", with_byte(base_frame(), 36, 8'h0c), 11'h004, 11'h00f, 1, 0, 11'h400);
  endtask

  task automatic t_gate();
    clear_tbl(); tcp_rule(0, 2'd3, 11'h400); e_gate[0] = 2'b01; commit();
    classify("R3 gate 01", base_frame(), 11'h001, 11'h003, 0, 0, 11'h003);
    e_gate[0] = 2'b10; commit();
    classify("R3 gate 10", base_frame(), 11'h001, 11'h003, 0, 0, 11'h003);
  endtask

  task automatic t_src();
    clear_tbl(); tcp_rule(2, 2'd3, 11'h200);
    e_skey[2] = 11'h004; e_smsk[2] = 11'h7ff; commit();
    classify("R2 port match", base_frame(), 11'h004, 11'h011, 1, 2, 11'h200);
    classify("R2 port other", base_frame(), 11'h008, 11'h011, 0, 0, 11'h011);
    e_smsk[2] = 11'h003; commit();
    classify("R2 port masked", base_frame(), 11'h008, 11'h011, 1, 2, 11'h200);
  endtask

  task automatic t_modes();
    clear_tbl(); tcp_rule(1, 2'd0, 11'h0f0); commit();
    classify("R4 mode nop", base_frame(), 11'h001, 11'h3c3, 1, 1, 11'h3c3);
    e_mode[1] = 2'd1; commit();
    classify("R5 mode and", base_frame(), 11'h001, 11'h3c3, 1, 1, 11'h0c0);
    e_mode[1] = 2'd2; commit();
    classify("R5 mode or", base_frame(), 11'h001, 11'h3c3, 1, 1, 11'h3f3);
    e_mode[1] = 2'd3; commit();
    classify("R5 mode replace", base_frame(), 11'h001, 11'h3c3, 1, 1, 11'h0f0);
  endtask

  task automatic t_prio();
    clear_tbl();
    tcp_rule(1, 2'd3, 11'h002);
    tcp_rule(3, 2'd3, 11'h008);
    tcp_rule(2, 2'd3, 11'h004); e_gate[2] = 2'b00;
    commit();
    classify("R6 lowest wins", base_frame(), 11'h001, 11'h100, 1, 1, 11'h002);
    e_gate[1] = 2'b00; commit();
    classify("R6 next wins", base_frame(), 11'h001, 11'h100, 1, 3, 11'h008);
  endtask

  task automatic t_backpressure();
    clear_tbl(); tcp_rule(0, 2'd3, 11'h400); commit();
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_hdr = base_frame(); in_src_port = 11'h001; in_dflt_vec = 11'h001;
    @(posedge clk);
    @(negedge clk);
    in_hdr = with_byte(base_frame(), 27, 8'h11); in_dflt_vec = 11'h0f0;
    @(posedge clk);
    @(negedge clk);
    in_hdr = with_byte(base_frame(), 5, 8'h00); in_dflt_vec = 11'h00a;
    chk("R9 full stall ready", in_ready, 0);
    chk("R8 first out", out_vec, 11'h400);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 held valid", out_valid, 1);
      chk("R8 held vec", out_vec, 11'h400);
      chk("R8 held hit", out_hit, 1);
    end
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R9 second valid", out_valid, 1);
    chk("R9 second miss", out_hit, 0);
    chk("R9 second vec", out_vec, 11'h0f0);
    @(negedge clk);
    chk("R9 third valid", out_valid, 1);
    chk("R9 third vec", out_vec, 11'h400);
    @(negedge clk);
    chk("R9 drained", out_valid, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clear_tbl(); commit();
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flushed_miss();
    t_bytes();
    t_gate();
    t_src();
    t_modes();
    t_prio();
    t_backpressure();
    finish_run();
  end
endmodule